// File: doc/BRIEF.md
# Coincidence-Selected Freeze and Capture Test Array

This block is a small grid of configurable logic cells, each one a two-input lookup function backed by a single test storage bit. Every row has one row line and every column has one column line. A cell runs its own function only when both of its lines are low. When either line is high, the cell is frozen: it drives its stored bit and can take part in a serial shift path through the grid. Cells are switched individually by where a row line and a column line cross. In a single cycle, some cells can therefore run live while every other cell stays frozen. A conventional scan chain cannot do this, because it moves all of its flops into test mode at once. Clock-like and inverted nets are handled in the same way as any other net, so no test-only clock multiplexer is needed.

A built-in sequencer runs one complete test for each start strobe. It first freezes every cell and shifts the stimulus in. It then drops the row and column lines for the chosen cells for exactly one cycle, so that those cells capture their live function values. Finally it shifts every stored bit out, raises a one-cycle done flag and returns to idle with every line high. Outside of the single release cycle, the normal-mode outputs show the stored bits of the east column.

Top module: `xyft_array`

## Requirements
- R1: While reset is asserted and after it is released, every row and column line is high, done is 0, every stored bit is 0, and therefore scan_out and norm_out are 0.
- R2: A cell is live only when its row line and its column line are both 0. A 1 on either line freezes it, and a frozen cell drives its stored bit onto its output.
- R3: A live cell at row r and column c (index k = r*COLS + c) outputs bit {north, west} of the 4-bit table CELL_LUTS[4k+3:4k]. Its west input is norm_in[r] when c = 0 and otherwise the output of cell k-1. Its north input is norm_in[ROWS+c] when r = 0 and otherwise the output of cell k-COLS. norm_out[r] is the output of the last cell in row r.
- R4: A frozen cell keeps its stored bit unchanged whenever no shift is under way, including during idle.
- R5: On the clock edge that ends a live cycle, the cell stores its output value and keeps that value once it is frozen again.
- R6: Shifting happens only while every cell is frozen. The shift path runs in row-major order: cell 0 takes scan_in, cell k takes the bit of cell k-1, and scan_out shows the stored bit of cell N-1, where N = ROWS*COLS. The bit driven in load cycle i therefore ends up in cell N-1-i, and the bit seen in unload cycle j is the bit of cell N-1-j.
- R7: A start that is high on a clock edge while the block is idle begins a run. The run has N load cycles, then one release cycle, then N unload cycles, then one cycle with done = 1, and then the block is idle again with every line high.
- R8: row_mask and col_mask are sampled at start. A bit set to 1 selects that row or column. Exactly the cells whose row and column are both selected go live in the release cycle, and every other cell unloads the bit it was loaded with.
- R9: A start that is high while a run is in progress has no effect on that run's timing or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins one test run when idle |
| row_mask | input | ROWS | Rows selected for release, sampled at start |
| col_mask | input | COLS | Columns selected for release, sampled at start |
| scan_in | input | 1 | Serial stimulus, one bit per shift cycle |
| scan_out | output | 1 | Serial result, the stored bit of the last cell |
| done | output | 1 | One-cycle pulse at the end of a run |
| norm_in | input | ROWS+COLS | Edge inputs: west side per row in the low bits, north side per column in the high bits |
| norm_out | output | ROWS | East-column cell outputs |

## Verification
The hardest situation to create from the ports is a stuck value on one internal cell output, because that output is visible only during the single release cycle and only through the stored bit it leaves behind. The bench forces one cell's function output to the opposite of its fault-free value and runs a release that selects that cell. It then confirms that the unloaded stream differs from the fault-free prediction. The mixed live and frozen state is reached with random row and column masks, so partial rectangles of live cells feed from frozen neighbours. Directed runs cover an empty selection, a full selection, the corner cell on its own, and a start held high across a whole run.

// File: rtl/xyft_pkg.sv
package xyft_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_RELEASE,
      SQ_UNLOAD,
      SQ_DONE
   } seq_state_t;

   // Two-input lookup: the table index is {north, west}
   function automatic logic lut_eval(input logic [3:0] tbl, input logic west, input logic north);
      return tbl[{north, west}];
   endfunction

endpackage

// File: rtl/xyft_cell.sv
module xyft_cell #(
   parameter logic [3:0] LUT = 4'h6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic row_line,
   input  logic col_line,
   input  logic shift_en,
   input  logic chain_in,
   input  logic west_in,
   input  logic north_in,
   output logic cell_out,
   output logic latch_out
);

   logic frozen;
   logic fn_val;
   logic held_q;

   assign frozen = row_line | col_line;
   assign fn_val = xyft_pkg::lut_eval(LUT, west_in, north_in);

   // Live: track the function so the value is captured on refreeze.
   // Frozen: hold, or take the chain bit while shifting.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
      end else if (!frozen) begin
         held_q <= fn_val;
      end else if (shift_en) begin
         held_q <= chain_in;
      end
   end

   assign cell_out  = frozen ? held_q : fn_val;
   assign latch_out = held_q;

endmodule

// File: rtl/xyft_seq.sv
module xyft_seq #(
   parameter int ROWS = 4,
   parameter int COLS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [ROWS-1:0] row_mask,
   input  logic [COLS-1:0] col_mask,
   output logic [ROWS-1:0] row_line,
   output logic [COLS-1:0] col_line,
   output logic            shift_en,
   output logic            done
);
   import xyft_pkg::*;

   localparam int            NCELL = ROWS * COLS;
   localparam int            CW    = $clog2(NCELL + 1);
   localparam logic [CW-1:0] LAST  = CW'(NCELL - 1);

   seq_state_t      st_q;
   logic [CW-1:0]   cnt_q;
   logic [ROWS-1:0] rsel_q;
   logic [COLS-1:0] csel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         cnt_q  <= '0;
         rsel_q <= '0;
         csel_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  st_q   <= SQ_LOAD;
                  cnt_q  <= '0;
                  rsel_q <= row_mask;
                  csel_q <= col_mask;
               end
            end
            SQ_LOAD: begin
               if (cnt_q == LAST) begin
                  st_q  <= SQ_RELEASE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_RELEASE: begin
               st_q  <= SQ_UNLOAD;
               cnt_q <= '0;
            end
            SQ_UNLOAD: begin
               if (cnt_q == LAST) begin
                  st_q  <= SQ_DONE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign row_line = (st_q == SQ_RELEASE) ? ~rsel_q : '1;
   assign col_line = (st_q == SQ_RELEASE) ? ~csel_q : '1;
   assign shift_en = (st_q == SQ_LOAD) || (st_q == SQ_UNLOAD);
   assign done     = (st_q == SQ_DONE);

endmodule

// File: rtl/xyft_array.sv
module xyft_array #(
   parameter int                       ROWS      = 4,
   parameter int                       COLS      = 4,
   parameter logic [4*ROWS*COLS-1:0]   CELL_LUTS = 64'hE896_7E18_6E96_8E7E
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [ROWS-1:0]      row_mask,
   input  logic [COLS-1:0]      col_mask,
   input  logic                 scan_in,
   output logic                 scan_out,
   output logic                 done,
   input  logic [ROWS+COLS-1:0] norm_in,
   output logic [ROWS-1:0]      norm_out
);

   localparam int NCELL = ROWS * COLS;

   if (ROWS < 1 || COLS < 1) begin : g_bad_dim
      $error("xyft_array: ROWS and COLS must both be at least 1");
   end
   if (NCELL < 2 || NCELL > 1024) begin : g_bad_size
      $error("xyft_array: cell count must lie between 2 and 1024");
   end

   logic [ROWS-1:0]  row_line;
   logic [COLS-1:0]  col_line;
   logic             shift_en;
   logic [NCELL-1:0] cell_out;
   logic [NCELL-1:0] latch_q;

   xyft_seq #(
      .ROWS(ROWS),
      .COLS(COLS)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .row_mask(row_mask),
      .col_mask(col_mask),
      .row_line(row_line),
      .col_line(col_line),
      .shift_en(shift_en),
      .done    (done)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int K = r * COLS + c;
         logic west_w;
         logic north_w;
         logic chain_w;

         if (c == 0) begin : g_west_edge
            assign west_w = norm_in[r];
         end else begin : g_west_cell
            assign west_w = cell_out[K-1];
         end

         if (r == 0) begin : g_north_edge
            assign north_w = norm_in[ROWS+c];
         end else begin : g_north_cell
            assign north_w = cell_out[K-COLS];
         end

         if (K == 0) begin : g_chain_head
            assign chain_w = scan_in;
         end else begin : g_chain_link
            assign chain_w = latch_q[K-1];
         end

         xyft_cell #(
            .LUT(CELL_LUTS[4*K +: 4])
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .row_line (row_line[r]),
            .col_line (col_line[c]),
            .shift_en (shift_en),
            .chain_in (chain_w),
            .west_in  (west_w),
            .north_in (north_w),
            .cell_out (cell_out[K]),
            .latch_out(latch_q[K])
         );
      end
      assign norm_out[r] = cell_out[r*COLS + COLS - 1];
   end

   assign scan_out = latch_q[NCELL-1];

endmodule

// File: rtl/xyft_array_chk.sv
module xyft_array_chk #(
   parameter int ROWS = 4,
   parameter int COLS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 done,
   input logic                 shift_en,
   input logic [ROWS-1:0]      row_line,
   input logic [COLS-1:0]      col_line,
   input logic [ROWS*COLS-1:0] latch_q
);

   logic all_hi;
   assign all_hi = (&row_line) && (&col_line);

   AST_SHIFT_ALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> ((&row_line) || (&col_line))) else $error("shift with live cell"); // R6

   AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !all_hi |=> all_hi) else $error("release longer than one cycle"); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R7

   AST_DONE_ALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (all_hi && !shift_en)) else $error("done while not frozen"); // R7

   AST_DONE_AFTER_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(shift_en)) else $error("done without unload"); // R7

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (all_hi && !shift_en) |=> $stable(latch_q)) else $error("frozen bit changed"); // R4

endmodule

bind xyft_array xyft_array_chk #(
   .ROWS(ROWS),
   .COLS(COLS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .shift_en(shift_en),
   .row_line(row_line),
   .col_line(col_line),
   .latch_q (latch_q)
);

// File: tb/xyft_array_tb.sv
`timescale 1ns/1ps
module xyft_array_tb;

   localparam int                 ROWS = 4;
   localparam int                 COLS = 4;
   localparam int                 N    = ROWS * COLS;
   localparam logic [4*N-1:0]     LUTS = 64'hE896_7E18_6E96_8E7E;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [ROWS-1:0]      row_mask = '0;
   logic [COLS-1:0]      col_mask = '0;
   logic                 scan_in = 1'b0;
   logic                 scan_out;
   logic                 done;
   logic [ROWS+COLS-1:0] norm_in = '0;
   logic [ROWS-1:0]      norm_out;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   xyft_array #(.ROWS(ROWS), .COLS(COLS), .CELL_LUTS(LUTS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .row_mask(row_mask),
      .col_mask(col_mask), .scan_in(scan_in), .scan_out(scan_out),
      .done(done), .norm_in(norm_in), .norm_out(norm_out)
   );

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Prediction of unload stream (bit j = j-th unloaded bit) and live east outputs
   function automatic logic [N-1:0] predict(input logic [N-1:0] stim, input logic [ROWS-1:0] rm,
                                            input logic [COLS-1:0] cm, input logic [ROWS+COLS-1:0] nin,
                                            output logic [ROWS-1:0] east);
      logic [N-1:0] lat;
      logic [N-1:0] o;
      logic [N-1:0] u;
      logic w;
      logic n;
      logic f;
      for (int k = 0; k < N; k++) lat[k] = stim[N-1-k];
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            int k;
            k = r * COLS + c;
            if (c == 0) w = nin[r]; else w = o[k-1];
            if (r == 0) n = nin[ROWS+c]; else n = o[k-COLS];
            f = LUTS[4*k + {n, w}];
            o[k] = (rm[r] && cm[c]) ? f : lat[k];
         end
      end
      for (int r = 0; r < ROWS; r++) east[r] = o[r*COLS + COLS - 1];
      for (int j = 0; j < N; j++) u[j] = o[N-1-j];
      return u;
   endfunction

   task automatic run(input logic [N-1:0] stim, input logic [ROWS-1:0] rm, input logic [COLS-1:0] cm,
                      input logic [ROWS+COLS-1:0] nin, input logic hold_start,
                      output logic [N-1:0] cap, output logic [ROWS-1:0] east);
      @(negedge clk);
      start = 1'b1; row_mask = rm; col_mask = cm; norm_in = nin;
      @(negedge clk);
      start = hold_start;
      row_mask = ~rm; col_mask = ~cm;   // masks must have been sampled at start (R8)
      for (int i = 0; i < N; i++) begin
         scan_in = stim[i];
         @(negedge clk);
      end
      scan_in = 1'b0;
      east = norm_out;                  // release cycle
      chk(done == 1'b0, "R7 done low in release", done, 0);
      @(negedge clk);
      for (int j = 0; j < N; j++) begin
         cap[j] = scan_out;
         @(negedge clk);
      end
      chk(done == 1'b1, "R7 done after unload", done, 1);
      start = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
   endtask

   task automatic test(input logic [N-1:0] stim, input logic [ROWS-1:0] rm, input logic [COLS-1:0] cm,
                       input logic [ROWS+COLS-1:0] nin, input logic hold_start, input string tag);
      logic [N-1:0]    cap;
      logic [N-1:0]    expv;
      logic [ROWS-1:0] east;
      logic [ROWS-1:0] east_exp;
      expv = predict(stim, rm, cm, nin, east_exp);
      run(stim, rm, cm, nin, hold_start, cap, east);
      chk(cap == expv, {tag, " R2 R5 R6 R8 unload"}, cap, expv);
      chk(east == east_exp, {tag, " R3 release norm_out"}, east, east_exp);
      chk(norm_out == '0, {tag, " R4 idle norm_out zero after unload"}, norm_out, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [N-1:0]    cap;
      logic [N-1:0]    good;
      logic [ROWS-1:0] east;
      logic [ROWS-1:0] ee;
      int              seed_dummy;

      repeat (3) @(negedge clk);
      chk(done == 1'b0 && scan_out == 1'b0 && norm_out == '0, "R1 reset outputs",
          {done, scan_out, norm_out}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && scan_out == 1'b0 && norm_out == '0, "R1 after reset",
          {done, scan_out, norm_out}, 0);

      // R8: empty selection returns the stimulus unchanged
      test(16'hA5C3, 4'h0, 4'h0, 8'hFF, 1'b0, "empty-select");
      // R3: every cell live
      test(16'h0000, 4'hF, 4'hF, 8'h5A, 1'b0, "all-live");
      test(16'hFFFF, 4'hF, 4'hF, 8'hC3, 1'b0, "all-live-b");
      // corner cell alone
      test(16'h1234, 4'h1, 4'h1, 8'h01, 1'b0, "corner");
      // R9: start held high across the run
      test(16'h5E7B, 4'h6, 4'h9, 8'h9C, 1'b1, "R9 start-held");

      // R4: idle for a while, nothing moves
      repeat (10) @(negedge clk);
      chk(norm_out == '0 && done == 1'b0 && scan_out == 1'b0, "R4 idle hold",
          {done, scan_out, norm_out}, 0);

      // Random mixed live/frozen runs
      seed_dummy = $urandom(32'd1234);
      for (int t = 0; t < 24; t++) begin
         test(N'($urandom), ROWS'($urandom), COLS'($urandom), (ROWS+COLS)'($urandom), 1'b0, "random");
      end

      // Stuck-at on cell (1,2): force its function output to the opposite value
      good = predict(16'h3C96, 4'h2, 4'h4, 8'hA7, ee);
      if (good[N-1-6]) force u_dut.g_row[1].g_col[2].u_cell.fn_val = 1'b0;
      else             force u_dut.g_row[1].g_col[2].u_cell.fn_val = 1'b1;
      run(16'h3C96, 4'h2, 4'h4, 8'hA7, 1'b0, cap, east);
      release u_dut.g_row[1].g_col[2].u_cell.fn_val;
      chk(cap != good, "R5 R6 stuck-at detected", cap, good);
      chk(cap[N-1-6] != good[N-1-6], "R5 stuck bit position", cap[N-1-6], ~good[N-1-6]);
      test(16'h3C96, 4'h2, 4'h4, 8'hA7, 1'b0, "fault-removed");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule